// File: doc/BRIEF.md
# UART Flag, Status and Interrupt Controller

This block holds the event flags of a UART whose receive and transmit FIFOs are sixteen characters deep, and reports them together with both FIFO fill levels in one read-only status word. The serial shifter, the baud generator and the FIFO storage arrays live elsewhere. This block keeps only the occupancy counters for the two FIFOs and issues pop and flush strobes to the storage. Software acts on the block through a single-cycle action write. Each flag has its own clear bit and its own set bit in that word. Further bits pop a received character or flush either FIFO.

The receive-ready flag does not rise as soon as a character lands. A counter advanced by a one-per-bit-time tick must first reach a programmable delay, counted from the moment the receive FIFO stops being empty. The counter restarts each time that FIFO drains. Transmit-ready is raised when the transmit fill level drops to or below a programmable threshold. The control word supplies both values. It also supplies six interrupt enables. The interrupt line is the registered OR of each flag ANDed with its enable.

Top module: `uart_flag_ctrl`

## Requirements
- R1: While reset is asserted, status_o is all zero and irq_o is 0. On the first clock edge after release, transmit-ready (status bit 1) rises, because the empty transmit FIFO is at or below any threshold.
- R2: An action write with bit 0, 1, 2, 3 or 4 set clears receive-ready, overrun, break, framing error or parity error respectively. Bit 13 clears transmit-ready. The flag is 0 from the next edge. Status bits are: 0 receive-ready, 1 transmit-ready, 2 overrun, 3 break, 4 framing error, 5 parity error.
- R3: Action bits 5 to 9 set the same five flags in the same order, and bit 14 sets transmit-ready. When a set and a clear for one flag arrive together, the flag is set.
- R4: The receive fill level (status bits 10:6) rises by one for each rx_push_i. It falls by one on action bit 10, which also drives rx_pop_o in the same cycle when the FIFO is not empty. The transmit fill level (status bits 15:11) follows tx_push_i and tx_pop_i. No level ever exceeds 16.
- R5: Action bit 11 empties the receive level and bit 12 empties the transmit level, from the next edge. Each drives its flush strobe (rx_flush_o, tx_flush_o) in the same cycle.
- R6: An rx_push_i while the receive level is 16 and no pop is requested sets the overrun flag and leaves the level at 16.
- R7: A pulse on rx_brk_i, rx_fe_i or rx_pe_i sets the break, framing-error or parity-error flag at the next edge.
- R8: Receive-ready is set one edge after the delay counter reaches the delay in control bits 21:14. The counter advances on bit_tick_i while the receive FIFO is not empty and restarts whenever it is empty. A delay of 0 sets the flag one edge after the first character arrives.
- R9: Transmit-ready is set one edge after the transmit level changes from above the threshold in control bits 25:22 to at or below it.
- R10: irq_o equals, one cycle later, the OR over all flags of flag AND enable. The enables are control bits 0 to 5 for receive-ready, overrun, break, framing error, parity error and transmit-ready in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 26 | Control word: enables 5:0, delay 21:14, threshold 25:22 |
| act_we_i | input | 1 | Action write strobe, one cycle |
| act_i | input | 15 | Action word |
| bit_tick_i | input | 1 | One pulse per bit time |
| rx_push_i | input | 1 | Received character written to the receive FIFO |
| rx_brk_i | input | 1 | Break detected pulse |
| rx_fe_i | input | 1 | Framing error pulse |
| rx_pe_i | input | 1 | Parity error pulse |
| tx_push_i | input | 1 | Character written to the transmit FIFO |
| tx_pop_i | input | 1 | Shifter takes a character from the transmit FIFO |
| status_o | output | 16 | Flags 5:0, receive level 10:6, transmit level 15:11 |
| irq_o | output | 1 | Registered interrupt request |
| rx_pop_o | output | 1 | Pop strobe to receive storage |
| rx_flush_o | output | 1 | Flush strobe to receive storage |
| tx_flush_o | output | 1 | Flush strobe to transmit storage |

## Verification
The embedded assertions check several rules on every cycle. A set request always leaves its flag at 1 and a lone clear leaves it at 0. Levels stay within 0 to 16, and a flush always empties its level. A push into a full receive FIFO raises overrun. The delay counter holds without a tick and restarts while the receive FIFO is empty. With every enable off, the interrupt line stays low. Only the directed scenarios show the exact bit-time count before receive-ready rises, the restart after draining, and the threshold crossing that raises transmit-ready. They also show the placement of every status field and action bit, and the one-cycle lag of the interrupt.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  // status flag positions (also the flag register index)
  localparam int F_RRDY = 0;
  localparam int F_TRDY = 1;
  localparam int F_OE   = 2;
  localparam int F_BRK  = 3;
  localparam int F_FE   = 4;
  localparam int F_PE   = 5;
  localparam int NFLAG  = 6;

  // action word: receive-side flags cleared at CLR_BASE+k, set at SET_BASE+k
  localparam int ACT_CLR_BASE = 0;
  localparam int ACT_SET_BASE = 5;
  localparam int ACT_RX_POP   = 10;
  localparam int ACT_RX_FLUSH = 11;
  localparam int ACT_TX_FLUSH = 12;
  localparam int ACT_TRDY_CLR = 13;
  localparam int ACT_TRDY_SET = 14;
  localparam int ACT_W        = 15;

  // control word field offsets
  localparam int CTL_IE_LSB  = 0;
  localparam int CTL_IE_W    = 6;
  localparam int CTL_DLY_LSB = 14;
endpackage

// File: rtl/ufc_flag_reg.sv
module ufc_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic en, d;

  always_comb begin
    en = set_i | clr_i;
    d  = set_i;          // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= 1'b0;
    else if (en) q_o <= d;
  end

  a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  a_r2_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/ufc_level_ctr.sv
module ufc_level_ctr #(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o
);
  logic             do_push, do_pop, en;
  logic [LVL_W-1:0] nxt;

  always_comb begin
    full_o  = (level_o == LVL_W'(DEPTH));
    empty_o = (level_o == '0);
    do_pop  = pop_i & ~empty_o;
    do_push = push_i & (~full_o | do_pop);
    en      = flush_i | do_push | do_pop;
    if (flush_i) nxt = '0;
    else         nxt = level_o + LVL_W'(do_push) - LVL_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  level_o <= '0;
    else if (en) level_o <= nxt;
  end

  a_r4_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    level_o <= LVL_W'(DEPTH));
  a_r5_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (level_o == '0));
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i && !flush_i) |=> (level_o == LVL_W'(DEPTH)));
endmodule

// File: rtl/ufc_rx_delay.sv
module ufc_rx_delay #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             empty_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             rise_o
);
  logic [DLY_W-1:0] cnt, cnt_nxt;
  logic             cnt_en, done, done_q;

  always_comb begin
    done    = ~empty_i & (cnt >= dly_i);
    cnt_en  = empty_i | (tick_i & (cnt < dly_i));
    cnt_nxt = empty_i ? '0 : cnt + 1'b1;
    rise_o  = done & ~done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      if (cnt_en) cnt <= cnt_nxt;
      done_q <= done;
    end
  end

  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    empty_i |=> (cnt == '0));
  a_r8_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_i && !tick_i) |=> $stable(cnt));
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DLY_W = 8,
  parameter int THR_W = 4
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic [CTL_DLY_LSB+DLY_W+THR_W-1:0]       ctrl_i,
  input  logic                                     act_we_i,
  input  logic [ACT_W-1:0]                         act_i,
  input  logic                                     bit_tick_i,
  input  logic                                     rx_push_i,
  input  logic                                     rx_brk_i,
  input  logic                                     rx_fe_i,
  input  logic                                     rx_pe_i,
  input  logic                                     tx_push_i,
  input  logic                                     tx_pop_i,
  output logic [NFLAG+2*$clog2(DEPTH+1)-1:0]       status_o,
  output logic                                     irq_o,
  output logic                                     rx_pop_o,
  output logic                                     rx_flush_o,
  output logic                                     tx_flush_o
);
  localparam int LVL_W   = $clog2(DEPTH + 1);
  localparam int THR_LSB = CTL_DLY_LSB + DLY_W;
  localparam int NRXF    = 5;
  // receive-side flags in action-word order
  localparam int RXF_IDX [NRXF] = '{F_RRDY, F_OE, F_BRK, F_FE, F_PE};
  // enable bit k of the control word guards flag EN_IDX[k]
  localparam int EN_IDX [NFLAG] = '{F_RRDY, F_OE, F_BRK, F_FE, F_PE, F_TRDY};

  logic [ACT_W-1:0] act_v;
  logic [LVL_W-1:0] rx_lvl, tx_lvl;
  logic             rx_full, rx_empty, tx_full, tx_empty;
  logic             rrdy_hw, oe_hw, trdy_hw, thr_ok, thr_q;
  logic [NFLAG-1:0] f_set, f_clr, flags, en_map;
  logic             irq_d;
  logic             unused_ctl;

  assign unused_ctl = ^{ctrl_i[CTL_DLY_LSB-1:CTL_IE_W], tx_full, tx_empty};

  always_comb act_v = act_we_i ? act_i : '0;

  ufc_level_ctr #(.DEPTH(DEPTH)) u_rx_lvl (
    .clk(clk), .rst_n(rst_n), .push_i(rx_push_i), .pop_i(act_v[ACT_RX_POP]),
    .flush_i(act_v[ACT_RX_FLUSH]), .level_o(rx_lvl), .full_o(rx_full), .empty_o(rx_empty));

  ufc_level_ctr #(.DEPTH(DEPTH)) u_tx_lvl (
    .clk(clk), .rst_n(rst_n), .push_i(tx_push_i), .pop_i(tx_pop_i),
    .flush_i(act_v[ACT_TX_FLUSH]), .level_o(tx_lvl), .full_o(tx_full), .empty_o(tx_empty));

  ufc_rx_delay #(.DLY_W(DLY_W)) u_rx_dly (
    .clk(clk), .rst_n(rst_n), .tick_i(bit_tick_i), .empty_i(rx_empty),
    .dly_i(ctrl_i[CTL_DLY_LSB +: DLY_W]), .rise_o(rrdy_hw));

  always_comb begin
    oe_hw   = rx_push_i & rx_full & ~act_v[ACT_RX_POP];
    thr_ok  = int'(tx_lvl) <= int'(ctrl_i[THR_LSB +: THR_W]);
    trdy_hw = thr_ok & ~thr_q;
  end

  // set/clear requests per flag
  always_comb begin
    f_set = '0;
    f_clr = '0;
    for (int k = 0; k < NRXF; k++) begin
      f_set[RXF_IDX[k]] = act_v[ACT_SET_BASE + k];
      f_clr[RXF_IDX[k]] = act_v[ACT_CLR_BASE + k];
    end
    f_set[F_RRDY] = f_set[F_RRDY] | rrdy_hw;
    f_set[F_OE]   = f_set[F_OE]   | oe_hw;
    f_set[F_BRK]  = f_set[F_BRK]  | rx_brk_i;
    f_set[F_FE]   = f_set[F_FE]   | rx_fe_i;
    f_set[F_PE]   = f_set[F_PE]   | rx_pe_i;
    f_set[F_TRDY] = act_v[ACT_TRDY_SET] | trdy_hw;
    f_clr[F_TRDY] = act_v[ACT_TRDY_CLR];
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    ufc_flag_reg u_flag (
      .clk(clk), .rst_n(rst_n), .set_i(f_set[g]), .clr_i(f_clr[g]), .q_o(flags[g]));
  end

  always_comb begin
    en_map = '0;
    for (int k = 0; k < NFLAG; k++) en_map[EN_IDX[k]] = ctrl_i[CTL_IE_LSB + k];
    irq_d = |(flags & en_map);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      thr_q <= thr_ok;
      irq_o <= irq_d;
    end
  end

  always_comb begin
    status_o   = {tx_lvl, rx_lvl, flags};
    rx_pop_o   = act_v[ACT_RX_POP] & ~rx_empty;
    rx_flush_o = act_v[ACT_RX_FLUSH];
    tx_flush_o = act_v[ACT_TX_FLUSH];
  end

  a_r6_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_i && rx_full && !act_v[ACT_RX_POP]) |=> status_o[F_OE]);
  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[CTL_IE_LSB +: CTL_IE_W] == '0) |=> !irq_o);
  a_r7_brk_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_brk_i |=> status_o[F_BRK]);
endmodule

// File: tb/test_uart_flag_ctrl.sv
module test_uart_flag_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [25:0] ctrl_i;
  logic        act_we_i;
  logic [14:0] act_i;
  logic        bit_tick_i, rx_push_i, rx_brk_i, rx_fe_i, rx_pe_i, tx_push_i, tx_pop_i;
  logic [15:0] status_o;
  logic        irq_o, rx_pop_o, rx_flush_o, tx_flush_o;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  uart_flag_ctrl i_uart_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .act_we_i(act_we_i), .act_i(act_i),
    .bit_tick_i(bit_tick_i), .rx_push_i(rx_push_i), .rx_brk_i(rx_brk_i),
    .rx_fe_i(rx_fe_i), .rx_pe_i(rx_pe_i), .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i),
    .status_o(status_o), .irq_o(irq_o), .rx_pop_o(rx_pop_o),
    .rx_flush_o(rx_flush_o), .tx_flush_o(tx_flush_o));

  function automatic logic [25:0] mk_ctrl(logic [5:0] ie, logic [7:0] dly, logic [3:0] thr);
    return {thr, dly, 8'h00, ie};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic do_act(logic [14:0] v);
    act_we_i = 1'b1; act_i = v;
    step();
    act_we_i = 1'b0; act_i = '0;
  endtask

  task automatic push_rx(int n);
    repeat (n) begin rx_push_i = 1'b1; step(); rx_push_i = 1'b0; end
  endtask

  task automatic ticks(int n);
    repeat (n) begin bit_tick_i = 1'b1; step(); bit_tick_i = 1'b0; end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(3);
    chk("R1 status in reset", 32'(status_o), 32'h0);
    chk("R1 irq in reset", 32'(irq_o), 32'h0);
    rst_n = 1'b1;
    step();
    chk("R1 trdy after release", 32'(status_o), 32'h0002);
  endtask

  task automatic t_set_clear;
    ctrl_i = mk_ctrl(6'h00, 8'hFF, 4'h0);
    do_act(15'h03E0);
    chk("R3 set five flags", 32'(status_o[5:0]), 32'h3F);
    do_act(15'h001F);
    chk("R2 clear five flags", 32'(status_o[5:0]), 32'h02);
    do_act(15'h0210);
    chk("R3 set wins over clear", 32'(status_o[5:0]), 32'h22);
    do_act(15'h2000);
    chk("R2 clear trdy", 32'(status_o[5:0]), 32'h20);
    do_act(15'h4000);
    chk("R3 set trdy", 32'(status_o[5:0]), 32'h22);
    do_act(15'h0010);
    chk("R2 clear pe", 32'(status_o[5:0]), 32'h02);
  endtask

  task automatic t_levels;
    ctrl_i = mk_ctrl(6'h00, 8'hFF, 4'h1);
    push_rx(3);
    chk("R4 rx level 3", 32'(status_o[10:6]), 32'd3);
    act_we_i = 1'b1; act_i = 15'h0400;
    #1 chk("R4 rx_pop_o strobe", 32'(rx_pop_o), 32'h1);
    step(); act_we_i = 1'b0; act_i = '0;
    chk("R4 rx level after pop", 32'(status_o[10:6]), 32'd2);
    repeat (3) begin tx_push_i = 1'b1; step(); tx_push_i = 1'b0; end
    chk("R4 tx level 3", 32'(status_o[15:11]), 32'd3);
    do_act(15'h2000);
    tx_pop_i = 1'b1; step(); tx_pop_i = 1'b0;
    step();
    chk("R9 trdy stays low above threshold", 32'(status_o[1]), 32'h0);
    tx_pop_i = 1'b1; step(); tx_pop_i = 1'b0;
    chk("R9 trdy not yet", 32'(status_o[1]), 32'h0);
    step();
    chk("R9 trdy at threshold", 32'(status_o[1]), 32'h1);
    chk("R4 tx level 1", 32'(status_o[15:11]), 32'd1);
  endtask

  task automatic t_overrun_flush;
    push_rx(14);
    chk("R4 rx level full", 32'(status_o[10:6]), 32'd16);
    chk("R6 no overrun yet", 32'(status_o[2]), 32'h0);
    push_rx(1);
    chk("R6 overrun set", 32'(status_o[2]), 32'h1);
    chk("R6 level held at 16", 32'(status_o[10:6]), 32'd16);
    act_we_i = 1'b1; act_i = 15'h0800;
    #1 chk("R5 rx_flush_o strobe", 32'(rx_flush_o), 32'h1);
    step(); act_we_i = 1'b0; act_i = '0;
    chk("R5 rx level flushed", 32'(status_o[10:6]), 32'd0);
    act_we_i = 1'b1; act_i = 15'h1000;
    #1 chk("R5 tx_flush_o strobe", 32'(tx_flush_o), 32'h1);
    step(); act_we_i = 1'b0; act_i = '0;
    chk("R5 tx level flushed", 32'(status_o[15:11]), 32'd0);
    do_act(15'h201F);
  endtask

  task automatic t_rx_delay;
    ctrl_i = mk_ctrl(6'h00, 8'd3, 4'h1);
    push_rx(1);
    ticks(2);
    chk("R8 rrdy low after 2 ticks", 32'(status_o[0]), 32'h0);
    ticks(1);
    chk("R8 rrdy low at count edge", 32'(status_o[0]), 32'h0);
    step();
    chk("R8 rrdy after delay", 32'(status_o[0]), 32'h1);
    do_act(15'h0401);
    chk("R8 drained and cleared", 32'(status_o[0]), 32'h0);
    push_rx(1);
    ticks(2);
    step(2);
    chk("R8 counter restarted", 32'(status_o[0]), 32'h0);
    ticks(1);
    step();
    chk("R8 rrdy after restart", 32'(status_o[0]), 32'h1);
    do_act(15'h0401);
    ctrl_i = mk_ctrl(6'h00, 8'd0, 4'h1);
    push_rx(1);
    chk("R8 zero delay not same edge", 32'(status_o[0]), 32'h0);
    step();
    chk("R8 zero delay next edge", 32'(status_o[0]), 32'h1);
    do_act(15'h0401);
  endtask

  task automatic t_hw_flags;
    rx_brk_i = 1'b1; step(); rx_brk_i = 1'b0;
    chk("R7 break flag", 32'(status_o[3]), 32'h1);
    rx_fe_i = 1'b1; step(); rx_fe_i = 1'b0;
    chk("R7 framing flag", 32'(status_o[4]), 32'h1);
    rx_pe_i = 1'b1; step(); rx_pe_i = 1'b0;
    chk("R7 parity flag", 32'(status_o[5]), 32'h1);
    do_act(15'h201F);
    chk("R2 all cleared", 32'(status_o[5:0]), 32'h0);
  endtask

  task automatic t_irq;
    ctrl_i = mk_ctrl(6'b000100, 8'hFF, 4'h1);
    rx_fe_i = 1'b1; step(); rx_fe_i = 1'b0;
    step();
    chk("R10 masked flag no irq", 32'(irq_o), 32'h0);
    rx_brk_i = 1'b1; step(); rx_brk_i = 1'b0;
    chk("R10 irq lags flag", 32'(irq_o), 32'h0);
    step();
    chk("R10 irq on enabled flag", 32'(irq_o), 32'h1);
    do_act(15'h0004);
    chk("R10 irq held one cycle", 32'(irq_o), 32'h1);
    step();
    chk("R10 irq drops", 32'(irq_o), 32'h0);
    ctrl_i = mk_ctrl(6'b100000, 8'hFF, 4'h1);
    do_act(15'h4000);
    step();
    chk("R10 trdy enable", 32'(irq_o), 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; ctrl_i = '0; act_we_i = 1'b0; act_i = '0; bit_tick_i = 1'b0;
    rx_push_i = 1'b0; rx_brk_i = 1'b0; rx_fe_i = 1'b0; rx_pe_i = 1'b0;
    tx_push_i = 1'b0; tx_pop_i = 1'b0;
    t_reset();
    t_set_clear();
    t_levels();
    t_overrun_flush();
    t_rx_delay();
    t_hw_flags();
    t_irq();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule